// File: doc/BRIEF.md
# Linear Seizure Feature Classifier

This block turns three per-window EEG features into a binary seizure verdict. The features are a complexity measure and the power in two chosen frequency bands. Each feature is multiplied by its own weight and the three products are summed. The sum is then compared with a programmable threshold. The weights and the threshold are trained offline for each subject and written at run time through a small register-write port.

A feature extractor presents the three features once per 32-sample analysis window, one cycle wide, with `in_valid`. The block works through the three products with one shared multiplier. It then raises `out_valid` for a single cycle together with the verdict and the raw score. The score is in Q2.28 and sits on the 0 (no seizure) to 1 (seizure) scale the weights were trained toward. At 200 samples per second a window lasts 160 ms, so the few cycles of latency leave a very large margin before the next window arrives.

Register writes go into a staging copy. The classifier copies the staging copy into the set it uses at the moment it accepts a window. A write therefore never disturbs a computation that is already running.

Top module: `seizure_lin_classifier`

## Requirements
- R1: After reset the outputs are as follows: `out_valid` is 0, `out_seizure` is 0 and `out_score` is 0. All three weights are 0, and the threshold is 0x2000 (0.5 in signed Q1.14).
- R2: `out_score` is the signed 36-bit sum of the three products `in_cm*W0 + in_band_a*W1 + in_band_b*W2`. Each input and weight is a signed 16-bit Q1.14 value, so the result is in Q2.28. The sum is exact for every input and weight value, including full-scale negatives.
- R3: `out_seizure` is 1 exactly when the score is greater than or equal to the threshold shifted left by 14 bits and sign-extended. A score equal to the threshold gives 1, and one LSB below it gives 0.
- R4: `out_valid` rises on the fourth rising edge after the edge that accepts `in_valid`. It stays high for exactly one cycle, and no accepted window produces more than one pulse.
- R5: The block ignores `in_valid` while a window is being computed, that is, during the three edges after the accepting edge. Such a pulse neither changes the pending result nor produces an extra `out_valid` pulse.
- R6: A write with `cfg_we` = 1 stores `cfg_wdata` at the location given by `cfg_addr`. Address 0 holds the complexity weight W0, address 1 the first band weight W1, address 2 the second band weight W2, and address 3 the threshold.
- R7: A write takes effect from the first window accepted after the write. This holds even when the write falls in the same cycle as the accepting edge or while a computation is running. Such a write does not affect the window in flight.
- R8: `out_seizure` and `out_score` hold their values between `out_valid` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Feature strobe, one cycle per window |
| in_cm | input | 16 | Complexity feature, signed Q1.14 |
| in_band_a | input | 16 | First band power feature, signed Q1.14 |
| in_band_b | input | 16 | Second band power feature, signed Q1.14 |
| cfg_we | input | 1 | Parameter write enable |
| cfg_addr | input | 2 | Parameter address (0..2 weights, 3 threshold) |
| cfg_wdata | input | 16 | Parameter value, signed Q1.14 |
| out_valid | output | 1 | One-cycle result strobe |
| out_seizure | output | 1 | Verdict: 1 = seizure |
| out_score | output | 36 | Raw weighted sum, signed Q2.28 |

## Verification
The bench targets the following corner cases:

- **Threshold boundary.** The score is set exactly at the threshold and one LSB below it. A strict compare or a misaligned threshold shift would flip the verdict.
- **Full-scale negatives.** All three products are set to full-scale negatives. A narrow or zero-extended accumulator would report a wrong or positive score.
- **Parameter writes at awkward times.** Writes land on the accepting edge and in the middle of a computation. A design without the staging copy would mix old and new weights in the window in flight.
- **Strobes while busy.** A second strobe arrives while the block is busy. A design that restarts on it would emit a pulse late, or emit two pulses.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
    localparam int FEAT_W   = 16;
    localparam int FRAC_W   = 14;
    localparam int ACC_W    = 36;
    localparam int NUM_FEAT = 3;
    localparam int IDX_W    = $clog2(NUM_FEAT);
    localparam int CFG_AW   = 2;
    localparam int PROD_W   = 2 * FEAT_W;
    localparam int THR_ADDR = NUM_FEAT;

    typedef logic signed [FEAT_W-1:0] q_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    localparam q_t THR_RESET = q_t'(1 << (FRAC_W - 1));

    typedef struct packed {
        q_t [NUM_FEAT-1:0] w;
        q_t                thr;
    } coef_set_t;

    function automatic acc_t mul_ext(input q_t a, input q_t b);
        logic signed [PROD_W-1:0] p;
        p = a * b;
        return {{(ACC_W - PROD_W){p[PROD_W-1]}}, p};
    endfunction

    function automatic acc_t thr_ext(input q_t t);
        return {{(ACC_W - FEAT_W - FRAC_W){t[FEAT_W-1]}}, t, {FRAC_W{1'b0}}};
    endfunction
endpackage

// File: rtl/lfc_coef_bank.sv
module lfc_coef_bank
    import lfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CFG_AW-1:0] wr_addr,
    input  q_t                wr_data,
    input  logic              snap,
    output coef_set_t         active
);
    q_t        stage_w [NUM_FEAT];
    q_t        stage_thr;
    coef_set_t staged;

    generate
        for (genvar i = 0; i < NUM_FEAT; i++) begin : g_wreg
            always_ff @(posedge clk) begin
                if (rst)
                    stage_w[i] <= '0;
                else if (wr_en && wr_addr == CFG_AW'(i))
                    stage_w[i] <= wr_data;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            stage_thr <= THR_RESET;
        else if (wr_en && wr_addr == CFG_AW'(THR_ADDR))
            stage_thr <= wr_data;
    end

    always_comb begin
        for (int i = 0; i < NUM_FEAT; i++)
            staged.w[i] = stage_w[i];
        staged.thr = stage_thr;
    end

    // The working set is copied from the staging set only when a window
    // is accepted, so the window in flight never sees a fresh write.
    always_ff @(posedge clk) begin
        if (rst) begin
            active.w   <= '0;
            active.thr <= THR_RESET;
        end else if (snap) begin
            active <= staged;
        end
    end
endmodule

// File: rtl/lfc_mac_seq.sv
module lfc_mac_seq
    import lfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  q_t [NUM_FEAT-1:0] feat_in,
    input  q_t [NUM_FEAT-1:0] wgt,
    output logic              accept,
    output logic              busy,
    output logic              done,
    output acc_t              acc
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_FEAT - 1);

    q_t [NUM_FEAT-1:0] feat_r;
    logic [IDX_W-1:0]  idx;
    acc_t              prod;

    assign accept = start && !busy;

    always_comb prod = mul_ext(feat_r[idx], wgt[idx]);

    always_ff @(posedge clk) begin
        if (rst) begin
            feat_r <= '0;
            idx    <= '0;
            acc    <= '0;
            busy   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                feat_r <= feat_in;
                idx    <= '0;
                acc    <= '0;
                busy   <= 1'b1;
            end else if (busy) begin
                acc <= acc + prod;
                if (idx == LAST) begin
                    idx  <= '0;
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/lfc_decide.sv
module lfc_decide
    import lfc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic done,
    input  acc_t acc,
    input  q_t   thr,
    output logic out_valid,
    output logic out_seizure,
    output acc_t out_score
);
    logic hit;

    assign hit = acc >= thr_ext(thr);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_seizure <= 1'b0;
            out_score   <= '0;
        end else begin
            out_valid <= done;
            if (done) begin
                out_seizure <= hit;
                out_score   <= acc;
            end
        end
    end
endmodule

// File: rtl/seizure_lin_classifier.sv
module seizure_lin_classifier
    import lfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [FEAT_W-1:0] in_cm,
    input  logic [FEAT_W-1:0] in_band_a,
    input  logic [FEAT_W-1:0] in_band_b,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [FEAT_W-1:0] cfg_wdata,
    output logic              out_valid,
    output logic              out_seizure,
    output logic [ACC_W-1:0]  out_score
);
    q_t [NUM_FEAT-1:0] feat_vec;
    coef_set_t         coef;
    logic              accept_w;
    logic              busy_w;
    logic              done_w;
    acc_t              acc_w;
    acc_t              score_w;

    assign feat_vec[0] = q_t'(in_cm);
    assign feat_vec[1] = q_t'(in_band_a);
    assign feat_vec[2] = q_t'(in_band_b);

    lfc_coef_bank u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cfg_we),
        .wr_addr(cfg_addr),
        .wr_data(q_t'(cfg_wdata)),
        .snap   (accept_w),
        .active (coef)
    );

    lfc_mac_seq u_mac (
        .clk    (clk),
        .rst    (rst),
        .start  (in_valid),
        .feat_in(feat_vec),
        .wgt    (coef.w),
        .accept (accept_w),
        .busy   (busy_w),
        .done   (done_w),
        .acc    (acc_w)
    );

    lfc_decide u_dec (
        .clk        (clk),
        .rst        (rst),
        .done       (done_w),
        .acc        (acc_w),
        .thr        (coef.thr),
        .out_valid  (out_valid),
        .out_seizure(out_seizure),
        .out_score  (score_w)
    );

    assign out_score = score_w;
endmodule

// File: rtl/lfc_chk.sv
module lfc_chk
    import lfc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             accept,
    input logic             out_valid,
    input logic             out_seizure,
    input logic [ACC_W-1:0] out_score
);
    // R4
    pulse_once_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R4
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> ##4 out_valid);

    // R4
    no_orphan_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(accept, 5));

    // R5
    accept_gap_chk: assert property (@(posedge clk) disable iff (rst)
        accept |-> !$past(accept, 1) && !$past(accept, 2) && !$past(accept, 3));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_score) && $stable(out_seizure));
endmodule

bind seizure_lin_classifier lfc_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept_w),
    .out_valid  (out_valid),
    .out_seizure(out_seizure),
    .out_score  (out_score)
);

// File: tb/sim_seizure_lin_classifier.sv
module sim_seizure_lin_classifier;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_cm = '0, in_band_a = '0, in_band_b = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        out_valid, out_seizure;
    logic [35:0] out_score;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] m_w [3];
    logic [15:0] m_thr;

    always #(CLK_P/2) clk = ~clk;

    seizure_lin_classifier u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_cm(in_cm), .in_band_a(in_band_a), .in_band_b(in_band_b),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .out_valid(out_valid), .out_seizure(out_seizure), .out_score(out_score)
    );

    function automatic longint sx(input logic [15:0] v);
        return longint'($signed(v));
    endfunction

    function automatic longint exp_score(input logic [15:0] f0, f1, f2,
                                         input logic [15:0] w0, w1, w2);
        return sx(f0) * sx(w0) + sx(f1) * sx(w1) + sx(f2) * sx(w2);
    endfunction

    function automatic logic exp_hit(input longint s, input logic [15:0] t);
        return s >= sx(t) * 64'sd16384;
    endfunction

    task automatic chk(input logic ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        if (a == 2'd3) m_thr = d; else m_w[a] = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // One window; optional write at negedge index wr_at (0..4, -1 none),
    // optional stray strobe at negedge index stray_at (2 or 3, -1 none).
    task automatic run_window(input logic [15:0] f0, f1, f2,
                              input int wr_at, input logic [1:0] wa, input logic [15:0] wd,
                              input int stray_at);
        longint s;
        logic   h;
        s = exp_score(f0, f1, f2, m_w[0], m_w[1], m_w[2]);
        h = exp_hit(s, m_thr);
        @(negedge clk);
        in_valid = 1'b1; in_cm = f0; in_band_a = f1; in_band_b = f2;
        for (int n = 0; n <= 7; n++) begin
            if (n > 0) begin
                @(negedge clk);
                in_valid = 1'b0;
                cfg_we   = 1'b0;
            end
            if (n == wr_at) begin
                cfg_we = 1'b1; cfg_addr = wa; cfg_wdata = wd;
                if (wa == 2'd3) m_thr = wd; else m_w[wa] = wd;
            end
            if (n == stray_at) begin
                in_valid = 1'b1;
                in_cm = ~f0; in_band_a = ~f1; in_band_b = ~f2;
            end
            if (n >= 1 && n <= 4)
                chk(out_valid == 1'b0, "R4 early valid", longint'(out_valid), 0);
            if (n == 5) begin
                chk(out_valid == 1'b1, "R4 valid pulse", longint'(out_valid), 1);
                chk(longint'($signed(out_score)) == s, "R2 score",
                    longint'($signed(out_score)), s);
                chk(out_seizure == h, "R3 verdict", longint'(out_seizure), longint'(h));
            end
            if (n >= 6) begin
                chk(out_valid == 1'b0, "R4/R5 extra pulse", longint'(out_valid), 0);
                chk(longint'($signed(out_score)) == s, "R8 score hold",
                    longint'($signed(out_score)), s);
            end
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd2011));
        m_w[0] = '0; m_w[1] = '0; m_w[2] = '0; m_thr = 16'h2000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(out_valid == 1'b0, "R1 valid", longint'(out_valid), 0);
        chk(out_seizure == 1'b0, "R1 seizure", longint'(out_seizure), 0);
        chk(out_score == '0, "R1 score", longint'(out_score), 0);
        // R1: zero weights give zero score, below 0.5
        run_window(16'h4000, 16'h4000, 16'h4000, -1, 2'd0, 16'h0, -1);

        // R6 / R3: W0 = 1.0, default threshold 0.5 boundary
        cfg_write(2'd0, 16'h4000);
        run_window(16'h2000, 16'h0000, 16'h0000, -1, 2'd0, 16'h0, -1);
        chk(out_seizure == 1'b1, "R3 equal to threshold", longint'(out_seizure), 1);
        run_window(16'h1FFF, 16'h0000, 16'h0000, -1, 2'd0, 16'h0, -1);
        chk(out_seizure == 1'b0, "R3 one below threshold", longint'(out_seizure), 0);

        // R6 address map: each weight on its own feature
        cfg_write(2'd1, 16'h2000);
        cfg_write(2'd2, 16'hC000);
        run_window(16'h0000, 16'h4000, 16'h0000, -1, 2'd0, 16'h0, -1);
        run_window(16'h0000, 16'h0000, 16'h4000, -1, 2'd0, 16'h0, -1);

        // R2 full-scale negatives
        cfg_write(2'd0, 16'h8000);
        cfg_write(2'd1, 16'h8000);
        cfg_write(2'd2, 16'h8000);
        run_window(16'h8000, 16'h8000, 16'h8000, -1, 2'd0, 16'h0, -1);
        run_window(16'h7FFF, 16'h7FFF, 16'h7FFF, -1, 2'd0, 16'h0, -1);

        // R6 negative threshold
        cfg_write(2'd3, 16'hE000);
        run_window(16'h0001, 16'h0000, 16'h0000, -1, 2'd0, 16'h0, -1);

        // R7 write on accepting edge and during compute
        run_window(16'h1000, 16'h1000, 16'h1000, 0, 2'd0, 16'h0100, -1);
        run_window(16'h1000, 16'h1000, 16'h1000, 2, 2'd3, 16'h7000, -1);
        run_window(16'h1000, 16'h1000, 16'h1000, -1, 2'd0, 16'h0, -1);

        // R5 strobes while busy
        run_window(16'h3000, 16'hF000, 16'h0800, -1, 2'd0, 16'h0, 2);
        run_window(16'h3000, 16'hF000, 16'h0800, -1, 2'd0, 16'h0, 3);

        // Random windows with random mid-window writes
        for (int k = 0; k < 60; k++) begin
            logic [15:0] r0, r1, r2, wd;
            int wat, sat;
            r0 = 16'($urandom); r1 = 16'($urandom); r2 = 16'($urandom);
            wd = 16'($urandom);
            wat = ($urandom % 4 == 0) ? int'($urandom % 5) : -1;
            sat = ($urandom % 5 == 0) ? 2 + int'($urandom % 2) : -1;
            if (k % 10 == 0) cfg_write(2'(k / 10 % 4), 16'($urandom));
            run_window(r0, r1, r2, wat, 2'($urandom), wd, sat);
        end

        summary();
        $finish;
    end
endmodule